// File: doc/BRIEF.md
# Configurable SPI Encoder Reader

This block is an SPI master that reads an absolute position encoder once for each trigger pulse. A transaction is a short run of back-to-back transfers. Each transfer is 4 to 8 bits wide. For every transfer the block shifts out one command byte on MOSI and collects one byte from MISO. The received bits are packed into one word. Two separate byte-array masks, each followed by a right shift, then pull a right-aligned position and a set of status flags out of that word.

The serial clock is the system clock divided by a power of two. Clock polarity and sampling phase are configurable, and so is the use of chip select. Position and the error flag are registered outputs. They change only when the one-cycle done pulse rises. Parity and CRC are not checked.

Top module: `spienc_reader`

## Requirements
- R1: One SCLK half period lasts 2^`cfg_div` clock cycles (code 0 gives half period 1, code 7 gives 128). SCLK changes at no other time during a transaction.
- R2: After reset, `spi_cs_n` is 1, `done` is 0, and `pos` and `err` are 0. While idle, SCLK rests at the level given by `cfg_cpol` (0 = low, 1 = high).
- R3: With `cfg_cpha` = 0, MISO is sampled on the first (leading) edge of each SCLK cycle. With `cfg_cpha` = 1, it is sampled on the second (trailing) edge. The command bit changes on the opposite edge.
- R4: `cfg_width` values 4 to 8 give that many bits per transfer. Any other code gives 8 bits. Each bit takes exactly one full SCLK cycle (two edges).
- R5: A transaction has `cfg_xfers`+1 transfers (1 to 4).
  - Transfer i lands in byte slot `cfg_xfers`-i of the received word, so the first transfer occupies the most significant populated slot. Slot s spans bits 8s+7..8s.
  - Within a slot, the bits arrive MSB first and are right-aligned.
  - Unfilled bits of the word are 0.
- R6: MOSI sends the low `width` bits of each command slot, MSB first. The command uses the same slot order as R5.
- R7: `pos` = (received word AND `cfg_pos_mask`) shifted right by `cfg_pos_shift`.
- R8: `err` = 1 exactly when (received word AND `cfg_flag_mask`) shifted right by `cfg_flag_shift` is non-zero. An all-zero flag mask therefore turns error checking off, whatever the shift.
- R9: Chip select behaviour:
  - With `cfg_use_cs` = 1, `spi_cs_n` falls one half period before the first SCLK edge and rises after the last transfer.
  - With `cfg_use_cs` = 0, `spi_cs_n` stays high.
- R10: `done` is a single-cycle pulse one clock after the end of the transaction. `pos` and `err` update with it and hold their values until the next pulse.
- R11: A trigger that arrives while a transaction is running is ignored. It causes no extra edges and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trigger | input | 1 | Starts a transaction when idle |
| cfg_div | input | 3 | SCLK divide code (half period 2^code) |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Sampling edge select |
| cfg_width | input | 4 | Bits per transfer |
| cfg_xfers | input | 2 | Transfers per transaction minus one |
| cfg_use_cs | input | 1 | Enables the chip select output |
| cfg_cmd | input | 32 | Command byte array |
| cfg_pos_mask | input | 32 | Position mask byte array |
| cfg_pos_shift | input | 5 | Position right shift |
| cfg_flag_mask | input | 32 | Flag mask byte array |
| cfg_flag_shift | input | 5 | Flag right shift |
| spi_miso | input | 1 | Serial data from the encoder |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial command data |
| pos | output | 32 | Right-aligned position |
| err | output | 1 | Flag error indication |
| done | output | 1 | Result-valid pulse |

## Verification
The assertions assume that every configuration input holds still from the trigger until the done pulse. The pointer-range and divider-bound checks compare live state against `cfg_xfers`, `cfg_width` and `cfg_div`. The bench respects this by changing configuration only while idle and then waiting a few cycles before it triggers. The only input it moves during a transaction is a second trigger pulse. It also assumes the encoder changes MISO on the edge opposite to the sampling edge. The bench's encoder model does this by deriving the MISO bit index from the count of SCLK edges in the selected phase.

// File: rtl/spienc_pkg.sv
package spienc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TAIL
  } eng_state_t;

  // Legal widths pass through; anything else falls back to a full byte.
  function automatic logic [3:0] xfer_bits(input logic [3:0] code);
    return (code >= 4'd4 && code <= 4'd8) ? code : 4'd8;
  endfunction

endpackage

// File: rtl/spienc_divider.sv
module spienc_divider #(
  parameter int CODE_W = 3,
  localparam int CNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  assign half_m1 = CNT_W'((32'd1 << code) - 32'd1);
  assign tick    = run && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt <= half_m1); // R1

endmodule

// File: rtl/spienc_engine.sv
module spienc_engine
  import spienc_pkg::*;
#(
  parameter int MAX_XFERS = 4,
  localparam int XC_W   = $clog2(MAX_XFERS),
  localparam int WORD_W = 8 * MAX_XFERS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              use_cs,
  input  logic [3:0]        nbits,
  input  logic [XC_W-1:0]   nx_code,
  input  logic [WORD_W-1:0] cmd,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic [WORD_W-1:0] rx,
  output logic              fin
);

  eng_state_t        state;
  logic [XC_W-1:0]   xi, slot, xi_adv;
  logic [2:0]        bi, bi_adv;
  logic [XC_W+2:0]   bitpos;
  logic              lead_edge, last_ptr, first;

  assign slot      = nx_code - xi;
  assign bitpos    = {slot, bi};
  assign lead_edge = (sclk == cpol);
  assign last_ptr  = (xi == nx_code) && (bi == 3'd0);
  assign busy      = (state != ST_IDLE);
  assign mosi      = busy ? cmd[bitpos] : 1'b0;

  always_comb begin
    if (bi == 3'd0) begin
      xi_adv = xi + 1'b1;
      bi_adv = 3'(nbits - 4'd1);
    end else begin
      xi_adv = xi;
      bi_adv = bi - 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      sclk  <= 1'b0;
      cs_n  <= 1'b1;
      xi    <= '0;
      bi    <= '0;
      rx    <= '0;
      first <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (state)
        ST_IDLE: begin
          sclk <= cpol;
          cs_n <= 1'b1;
          if (start) begin
            state <= ST_SHIFT;
            cs_n  <= !use_cs;
            xi    <= '0;
            bi    <= 3'(nbits - 4'd1);
            rx    <= '0;
            first <= 1'b1;
          end
        end
        ST_SHIFT: if (tick) begin
          sclk <= ~sclk;
          if (lead_edge) begin
            first <= 1'b0;
            if (!cpha) rx[bitpos] <= miso;
            else if (!first) begin
              xi <= xi_adv;
              bi <= bi_adv;
            end
          end else begin
            if (cpha) rx[bitpos] <= miso;
            if (last_ptr) state <= ST_TAIL;
            else if (!cpha) begin
              xi <= xi_adv;
              bi <= bi_adv;
            end
          end
        end
        ST_TAIL: if (tick) begin
          cs_n  <= 1'b1;
          fin   <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> cs_n); // R9
  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(sclk)); // R1
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> xi <= nx_code); // R5
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> {1'b0, bi} < nbits); // R4
  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin); // R10

endmodule

// File: rtl/spienc_extract.sv
module spienc_extract #(
  parameter int WORD_W = 32,
  localparam int SH_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] pos_mask,
  input  logic [SH_W-1:0]   pos_shift,
  input  logic [WORD_W-1:0] flag_mask,
  input  logic [SH_W-1:0]   flag_shift,
  output logic [WORD_W-1:0] pos_val,
  output logic              flag_hit
);

  logic [WORD_W-1:0] flags;

  assign pos_val  = (word & pos_mask) >> pos_shift;
  assign flags    = (word & flag_mask) >> flag_shift;
  assign flag_hit = |flags;

endmodule

// File: rtl/spienc_reader.sv
module spienc_reader
  import spienc_pkg::*;
#(
  parameter int MAX_XFERS  = 4,
  parameter int DIV_CODE_W = 3,
  localparam int XC_W   = $clog2(MAX_XFERS),
  localparam int WORD_W = 8 * MAX_XFERS,
  localparam int SH_W   = $clog2(WORD_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trigger,
  input  logic [DIV_CODE_W-1:0] cfg_div,
  input  logic                  cfg_cpol,
  input  logic                  cfg_cpha,
  input  logic [3:0]            cfg_width,
  input  logic [XC_W-1:0]       cfg_xfers,
  input  logic                  cfg_use_cs,
  input  logic [WORD_W-1:0]     cfg_cmd,
  input  logic [WORD_W-1:0]     cfg_pos_mask,
  input  logic [SH_W-1:0]       cfg_pos_shift,
  input  logic [WORD_W-1:0]     cfg_flag_mask,
  input  logic [SH_W-1:0]       cfg_flag_shift,
  input  logic                  spi_miso,
  output logic                  spi_sclk,
  output logic                  spi_cs_n,
  output logic                  spi_mosi,
  output logic [WORD_W-1:0]     pos,
  output logic                  err,
  output logic                  done
);

  logic              busy, tick, fin, err_c;
  logic [3:0]        nbits;
  logic [WORD_W-1:0] rx, pos_c;

  assign nbits = xfer_bits(cfg_width);

  spienc_divider #(.CODE_W(DIV_CODE_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .code(cfg_div), .tick(tick)
  );

  spienc_engine #(.MAX_XFERS(MAX_XFERS)) u_eng (
    .clk(clk), .rst(rst), .start(trigger), .tick(tick),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .use_cs(cfg_use_cs),
    .nbits(nbits), .nx_code(cfg_xfers), .cmd(cfg_cmd), .miso(spi_miso),
    .busy(busy), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .rx(rx), .fin(fin)
  );

  spienc_extract #(.WORD_W(WORD_W)) u_ext (
    .word(rx), .pos_mask(cfg_pos_mask), .pos_shift(cfg_pos_shift),
    .flag_mask(cfg_flag_mask), .flag_shift(cfg_flag_shift),
    .pos_val(pos_c), .flag_hit(err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      err  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        pos <= pos_c;
        err <= err_c;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_ERR_OFF: assert property (@(posedge clk) disable iff (rst)
    (done && cfg_flag_mask == '0) |-> !err); // R8
  AST_NO_CS: assert property (@(posedge clk) disable iff (rst)
    (!cfg_use_cs && $past(!cfg_use_cs)) |-> spi_cs_n); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pos) && $stable(err))); // R10

endmodule

// File: tb/spienc_reader_test.sv
module spienc_reader_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst = 1'b1, trigger = 1'b0;
  logic [2:0]  cfg_div = '0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_use_cs = 1'b1;
  logic [3:0]  cfg_width = 4'd8;
  logic [1:0]  cfg_xfers = '0;
  logic [31:0] cfg_cmd = '0, cfg_pos_mask = '0, cfg_flag_mask = '0;
  logic [4:0]  cfg_pos_shift = '0, cfg_flag_shift = '0;
  logic        spi_miso, spi_sclk, spi_cs_n, spi_mosi, err, done;
  logic [31:0] pos;

  spienc_reader uut (
    .clk(clk), .rst(rst), .trigger(trigger), .cfg_div(cfg_div),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_width(cfg_width),
    .cfg_xfers(cfg_xfers), .cfg_use_cs(cfg_use_cs), .cfg_cmd(cfg_cmd),
    .cfg_pos_mask(cfg_pos_mask), .cfg_pos_shift(cfg_pos_shift),
    .cfg_flag_mask(cfg_flag_mask), .cfg_flag_shift(cfg_flag_shift),
    .spi_miso(spi_miso), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .pos(pos), .err(err), .done(done)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total_chk = 0, bad_chk = 0;
  int cyc = 0;
  always @(negedge clk) cyc++;

  // encoder model state
  logic [31:0] seq_rx = '0, cap = '0;
  int edge_total = 0, edge_base = 0;
  int first_edge_cyc = 0, second_edge_cyc = 0;
  int cs_fall_cyc = 0, cs_rise_cyc = 0, cs_fall_cnt = 0;
  int done_cyc = 0, done_cnt = 0, done_long = 0;
  logic done_prev = 1'b0;
  int rel_now, miso_idx;

  assign rel_now  = edge_total - edge_base;
  assign miso_idx = cfg_cpha ? ((rel_now == 0) ? 0 : (rel_now - 1) / 2) : rel_now / 2;
  assign spi_miso = (miso_idx < 32) ? seq_rx[miso_idx] : 1'b0;

  always @(spi_sclk) begin
    int rel;
    edge_total++;
    rel = edge_total - edge_base;
    if (rel == 1) first_edge_cyc = cyc;
    if (rel == 2) second_edge_cyc = cyc;
    if (!cfg_cpha && rel % 2 == 1 && (rel - 1) / 2 < 32) cap[(rel - 1) / 2] = spi_mosi;
    if (cfg_cpha && rel % 2 == 0 && rel > 0 && rel / 2 - 1 < 32) cap[rel / 2 - 1] = spi_mosi;
  end

  always @(negedge spi_cs_n) begin cs_fall_cyc = cyc; cs_fall_cnt++; end
  always @(posedge spi_cs_n) cs_rise_cyc = cyc;
  always @(posedge done) begin done_cyc = cyc; done_cnt++; end
  always @(negedge clk) begin
    if (done && done_prev) done_long++;
    done_prev = done;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [2:0] div, input logic cpol, input logic cpha,
                         input logic [3:0] wcode, input logic [1:0] xcode, input logic usecs,
                         input logic [31:0] cmd, input logic [31:0] resp,
                         input logic [31:0] pmask, input logic [4:0] psh,
                         input logic [31:0] fmask, input logic [4:0] fsh,
                         input bit retrig);
    int nb, nx, tot, dbase, cbase, half;
    logic [31:0] rxexp, seq_tx, exp_pos;
    bit exp_err, cmd_ok;
    nb = (wcode >= 4 && wcode <= 8) ? int'(wcode) : 8;
    nx = int'(xcode) + 1;
    tot = nb * nx;
    half = 1 << div;
    rxexp = '0;
    seq_tx = '0;
    @(negedge clk);
    cfg_div = div; cfg_cpol = cpol; cfg_cpha = cpha; cfg_width = wcode;
    cfg_xfers = xcode; cfg_use_cs = usecs; cfg_cmd = cmd;
    cfg_pos_mask = pmask; cfg_pos_shift = psh;
    cfg_flag_mask = fmask; cfg_flag_shift = fsh;
    for (int k = 0; k < tot; k++) begin
      int t, j, s;
      t = k / nb; j = nb - 1 - (k % nb); s = nx - 1 - t;
      seq_rx[k] = resp[s*8 + j];
      seq_tx[k] = cmd[s*8 + j];
      rxexp[s*8 + j] = resp[s*8 + j];
    end
    exp_pos = (rxexp & pmask) >> psh;
    exp_err = |((rxexp & fmask) >> fsh);
    repeat (3) @(negedge clk);
    edge_base = edge_total;
    dbase = done_cnt;
    cbase = cs_fall_cnt;
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    if (retrig) begin
      repeat (20) @(negedge clk);
      trigger = 1'b1;
      @(negedge clk);
      trigger = 1'b0;
    end
    for (int w = 0; w < 20000 && done_cnt == dbase; w++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(pos == exp_pos, "R7 R3 R5", "position", pos, exp_pos);
    check(err == exp_err, "R8", "error flag", err, exp_err);
    check(edge_total - edge_base == 2 * tot, "R4 R5 R11", "sclk edges", edge_total - edge_base, 2 * tot);
    cmd_ok = 1'b1;
    for (int k = 0; k < tot; k++) if (cap[k] !== seq_tx[k]) cmd_ok = 1'b0;
    check(cmd_ok, "R6", "mosi stream", cap, seq_tx);
    check(second_edge_cyc - first_edge_cyc == half, "R1", "half period", second_edge_cyc - first_edge_cyc, half);
    check(done_cnt - dbase == 1, "R10 R11", "done pulses", done_cnt - dbase, 1);
    check(done_long == 0, "R10", "done wider than one cycle", done_long, 0);
    check(spi_sclk == cpol, "R2", "idle sclk", spi_sclk, cpol);
    if (usecs) begin
      check(cs_fall_cnt - cbase == 1, "R9", "cs falls", cs_fall_cnt - cbase, 1);
      check(first_edge_cyc - cs_fall_cyc == half, "R9", "cs lead", first_edge_cyc - cs_fall_cyc, half);
      check(done_cyc - cs_rise_cyc == 1, "R10", "done after cs release", done_cyc - cs_rise_cyc, 1);
    end else begin
      check(cs_fall_cnt - cbase == 0, "R9", "cs unused", cs_fall_cnt - cbase, 0);
    end
  endtask

  task automatic t_reset();
    check(spi_cs_n == 1'b1, "R2", "cs after reset", spi_cs_n, 1);
    check(done == 1'b0, "R2", "done after reset", done, 0);
    check(pos == 32'd0 && err == 1'b0, "R2", "pos/err after reset", pos, 0);
    @(negedge clk); cfg_cpol = 1'b1;
    repeat (2) @(negedge clk);
    check(spi_sclk == 1'b1, "R2", "sclk idle high", spi_sclk, 1);
    cfg_cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(spi_sclk == 1'b0, "R2", "sclk idle low", spi_sclk, 0);
  endtask

  // 16-bit reader, position 13:0, flag at bit 14, all-ones command
  task automatic t_two_bytes();
    run_txn(3'd1, 1'b0, 1'b0, 4'd8, 2'd1, 1'b1, 32'h0000_FFFF, 32'h0000_4ABC,
            32'h0000_3FFF, 5'd0, 32'h0000_4000, 5'd0, 1'b0);
    run_txn(3'd1, 1'b0, 1'b1, 4'd8, 2'd1, 1'b1, 32'h0000_FFFF, 32'h0000_0ABC,
            32'h0000_3FFF, 5'd0, 32'h0000_4000, 5'd0, 1'b0);
  endtask

  task automatic t_modes_six_bit();
    run_txn(3'd2, 1'b1, 1'b1, 4'd6, 2'd1, 1'b1, 32'h0000_2A15, 32'h0000_ED97,
            32'h0000_3F3C, 5'd2, 32'h0000_0003, 5'd1, 1'b0);
    run_txn(3'd0, 1'b1, 1'b0, 4'd6, 2'd1, 1'b1, 32'h0000_1B26, 32'h0000_2D35,
            32'h0000_3F3F, 5'd3, 32'h0000_0020, 5'd0, 1'b0);
  endtask

  task automatic t_widths();
    run_txn(3'd1, 1'b0, 1'b1, 4'd4, 2'd3, 1'b1, 32'h090A_0B0C, 32'hFAEB_DCC5,
            32'h0F0F_0F0F, 5'd0, 32'h0000_0000, 5'd7, 1'b0);
    run_txn(3'd0, 1'b0, 1'b0, 4'd2, 2'd0, 1'b1, 32'h0000_00A5, 32'h0000_00C3,
            32'h0000_00FF, 5'd0, 32'h0000_0080, 5'd7, 1'b0);
    run_txn(3'd1, 1'b1, 1'b1, 4'd7, 2'd2, 1'b1, 32'h0055_2A7F, 32'h00F3_8E41,
            32'h007F_7F7F, 5'd4, 32'h0040_0000, 5'd20, 1'b0);
  endtask

  task automatic t_slow_div();
    run_txn(3'd7, 1'b0, 1'b0, 4'd5, 2'd0, 1'b1, 32'h0000_0015, 32'h0000_000B,
            32'h0000_001F, 5'd0, 32'h0000_0010, 5'd0, 1'b0);
  endtask

  task automatic t_no_cs();
    run_txn(3'd1, 1'b0, 1'b0, 4'd8, 2'd1, 1'b0, 32'h0000_3C5A, 32'h0000_1234,
            32'h0000_FFFF, 5'd4, 32'h0000_8000, 5'd0, 1'b0);
  endtask

  task automatic t_retrigger();
    run_txn(3'd2, 1'b0, 1'b1, 4'd8, 2'd2, 1'b1, 32'h0012_3456, 32'h0089_ABCD,
            32'h00FF_FFFF, 5'd8, 32'h0080_0000, 5'd0, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_two_bytes();
    t_modes_six_bit();
    t_widths();
    t_slow_div();
    t_no_cs();
    t_retrigger();
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    #(CLK_NS * 190000);
    total_chk++;
    bad_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule